// File: doc/BRIEF.md
# Micro-frame interrupt threshold coalescer

This block sits between the event sources of a USB host/device controller and the single interrupt line to the processor. It limits how often that line can fire. Software sets a threshold, counted in micro-frames, that is the longest allowed gap between interrupts. Events that arrive while the gap is still open are collected into a pending set. When the gap closes, that whole set is reported in one interrupt.

The threshold is an 8-bit field at bits 23:16 of a 32-bit command word. Only a few codes are accepted. Code 0 selects pass-through: every event raises an interrupt on the next cycle. A micro-frame tick input advances an elapsed-interval counter. That counter restarts each time an interrupt goes out. Along with each single-cycle interrupt pulse, the block presents the set of sources that caused it.

Top module: `uframe_irq_coalescer`

## Requirements
- R1: After reset, cfg_rdata reads 0x0008_0000 (threshold code 0x08), and irq_o and irq_src_o are zero.
- R2: A write whose bits 23:16 hold 0x00, 0x01, 0x02, 0x08, 0x10, 0x20 or 0x40 loads that code. The code means that many micro-frames, with 0x00 meaning no threshold.
- R3: A write whose bits 23:16 hold any other code leaves the stored threshold unchanged.
- R4: Bits 31:24 and 15:0 of cfg_rdata always read zero. Writes to those bits have no effect.
- R5: With threshold 0, an event in cycle t makes irq_o high for exactly cycle t+1, and irq_src_o then equals that event vector.
- R6: With threshold T>0, suppose an event arrives after j micro-frame ticks have elapsed since the last interrupt. The interrupt then follows tick number max(T, j+1), and irq_o is high in the cycle after that tick.
- R7: Events from different sources and cycles within one interval are ORed together. irq_src_o reports the OR, and the pending set is empty after the interrupt.
- R8: The elapsed-tick count restarts from zero at every interrupt, and it saturates at the threshold.
- R9: irq_o never rises while no event is pending, and it is high for one cycle per interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Command word write strobe |
| cfg_wdata | input | 32 | Command word write data (threshold in bits 23:16) |
| cfg_rdata | output | 32 | Command word read data |
| evt_i | input | NUM_SRC | Per-source event pulses |
| uf_tick_i | input | 1 | One-cycle pulse per micro-frame |
| irq_o | output | 1 | Interrupt pulse |
| irq_src_o | output | NUM_SRC | Sources reported with the interrupt |

## Verification
The hardest case to reach from the ports is an event that arrives after the counter has already saturated at the threshold. Such an event must fire on the very next tick, not a full interval later. To reach it, the bench first resynchronises the counter with a flushing interrupt. It then lets j empty ticks pass before a single event, sweeping j from 0 to two past the threshold for every legal code. Every one of the 256 codes is also written over a known baseline to confirm that reserved codes are rejected.

// File: rtl/uf_coal_pkg.sv
package uf_coal_pkg;
  localparam int          THR_W   = 8;
  localparam int          THR_LSB = 16;
  localparam int          MAX_UF  = 64;
  localparam logic [7:0]  THR_RST = 8'h08;

  // accepted threshold codes; every other code is reserved
  function automatic logic thr_code_ok(input logic [THR_W-1:0] c);
    case (c)
      8'h00, 8'h01, 8'h02, 8'h08, 8'h10, 8'h20, 8'h40: return 1'b1;
      default:                                         return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/uf_thr_reg.sv
module uf_thr_reg
  import uf_coal_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [THR_W-1:0]  thr_o,
  output logic [DATA_W-1:0] rd_data
);
  logic [THR_W-1:0] thr_q, thr_d, wr_code;

  assign wr_code = wr_data[THR_LSB +: THR_W];

  always_comb begin
    thr_d = thr_q;
    if (wr_en && thr_code_ok(wr_code)) thr_d = wr_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) thr_q <= THR_RST;
    else        thr_q <= thr_d;
  end

  always_comb begin
    rd_data = '0;
    rd_data[THR_LSB +: THR_W] = thr_q;
  end

  assign thr_o = thr_q;

  // R3: reserved code written -> stored threshold unchanged
  a_r3_reserved_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !thr_code_ok(wr_code)) |=> $stable(thr_o));
  // R2: stored code is always an accepted one
  a_r2_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    thr_code_ok(thr_o));
endmodule

// File: rtl/uf_interval_ctr.sv
module uf_interval_ctr
  import uf_coal_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic [THR_W-1:0] thr,
  output logic             reached,
  output logic [THR_W-1:0] cnt_o
);
  logic [THR_W-1:0] cnt_q, cnt_d, cnt_inc;

  // saturate at the threshold so a late event waits only one tick
  assign cnt_inc = (cnt_q >= thr) ? cnt_q : cnt_q + 1'b1;
  assign reached = tick && (cnt_inc >= thr);

  always_comb begin
    cnt_d = cnt_q;
    if (restart)   cnt_d = '0;
    else if (tick) cnt_d = cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R8: counter never exceeds the largest interval
  a_r8_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_o <= THR_W'(MAX_UF));
  // R8: count only moves on a tick or a restart
  a_r8_cnt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart) |=> $stable(cnt_o));
endmodule

// File: rtl/uf_pend_latch.sv
module uf_pend_latch #(
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt,
  input  logic               clr,
  output logic [NUM_SRC-1:0] merged_o,
  output logic [NUM_SRC-1:0] pend_o
);
  logic [NUM_SRC-1:0] pend_q, pend_d;

  assign merged_o = pend_q | evt;

  always_comb begin
    pend_d = merged_o;
    if (clr) pend_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  // R7: a pending source stays pending until reported
  a_r7_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr) |=> ((pend_o & $past(pend_o)) == $past(pend_o)));
endmodule

// File: rtl/uframe_irq_coalescer.sv
module uframe_irq_coalescer
  import uf_coal_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [DATA_W-1:0]  cfg_wdata,
  output logic [DATA_W-1:0]  cfg_rdata,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               uf_tick_i,
  output logic               irq_o,
  output logic [NUM_SRC-1:0] irq_src_o
);
  logic [THR_W-1:0]   thr, cnt;
  logic               reached, immediate, fire;
  logic [NUM_SRC-1:0] merged, pend;
  logic               irq_q, irq_d;
  logic [NUM_SRC-1:0] src_q, src_d;

  uf_thr_reg #(.DATA_W(DATA_W)) u_thr (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_data(cfg_wdata),
    .thr_o(thr), .rd_data(cfg_rdata)
  );

  uf_interval_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .tick(uf_tick_i), .restart(fire),
    .thr(thr), .reached(reached), .cnt_o(cnt)
  );

  uf_pend_latch #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .evt(evt_i), .clr(fire),
    .merged_o(merged), .pend_o(pend)
  );

  assign immediate = (thr == '0);
  assign fire      = (|merged) && (immediate || reached);

  always_comb begin
    irq_d = fire;
    src_d = fire ? merged : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      src_q <= '0;
    end else begin
      irq_q <= irq_d;
      src_q <= src_d;
    end
  end

  assign irq_o     = irq_q;
  assign irq_src_o = src_q;

  // R8: interval restarts whenever an interrupt is issued
  a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (cnt == '0));
  // R7: pending set is empty right after reporting
  a_r7_pend_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (pend == '0));
  // R9: interrupt always carries at least one source
  a_r9_no_empty_irq: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (irq_src_o != '0));
  // R5: pass-through mode answers every event on the next cycle
  a_r5_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    (immediate && (evt_i != '0)) |=> irq_o);
  // R4: bytes outside the threshold field read zero
  a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[DATA_W-1:THR_LSB+THR_W] == '0) && (cfg_rdata[THR_LSB-1:0] == '0));
endmodule

// File: tb/tb_uframe_irq_coalescer.sv
`timescale 1ns/1ps
module tb_uframe_irq_coalescer;
  localparam int N = 4;
  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we;
  logic [31:0]   cfg_wdata, cfg_rdata;
  logic [N-1:0]  evt_i, irq_src_o;
  logic          uf_tick_i, irq_o;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  uframe_irq_coalescer #(.NUM_SRC(N), .DATA_W(32)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .evt_i(evt_i), .uf_tick_i(uf_tick_i),
    .irq_o(irq_o), .irq_src_o(irq_src_o)
  );

  function automatic bit legal(input logic [7:0] c);
    return c == 8'h00 || c == 8'h01 || c == 8'h02 || c == 8'h08 ||
           c == 8'h10 || c == 8'h20 || c == 8'h40;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic tick(output bit fired);
    @(negedge clk); uf_tick_i = 1'b1;
    @(negedge clk); uf_tick_i = 1'b0; fired = irq_o;
  endtask

  task automatic pulse(input logic [N-1:0] m, output bit fired);
    @(negedge clk); evt_i = m;
    @(negedge clk); evt_i = '0; fired = irq_o;
  endtask

  // flush: leaves counter at zero and pending empty
  task automatic sync();
    bit f;
    pulse(4'b0001, f);
    for (int i = 0; i < 80 && !f; i++) tick(f);
    chk(f, "R6 sync", f, 1);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual 0 expected 1");
    summary();
  end

  initial begin
    logic [7:0] codes [6] = '{8'h01, 8'h02, 8'h08, 8'h10, 8'h20, 8'h40};
    bit f;
    rst_n = 1'b0; cfg_we = 0; cfg_wdata = '0; evt_i = '0; uf_tick_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cfg_rdata == 32'h0008_0000, "R1", cfg_rdata, 32'h0008_0000);
    chk(irq_o == 0 && irq_src_o == 0, "R1 irq", {irq_o, irq_src_o}, 0);

    // R2 R3 R4: all 256 codes over a baseline, with stray bits set
    for (int v = 0; v < 256; v++) begin
      logic [7:0] e;
      wr(32'h0002_0000);
      wr(32'hFF00_FFFF | (32'(v) << 16));
      e = legal(8'(v)) ? 8'(v) : 8'h02;
      chk(cfg_rdata == {8'h00, e, 16'h0000}, legal(8'(v)) ? "R2" : "R3 R4",
          cfg_rdata, {8'h00, e, 16'h0000});
    end

    // R5 immediate mode
    wr(32'h0000_0000);
    for (int m = 1; m < 16; m++) begin
      pulse(4'(m), f);
      chk(f == 1 && irq_src_o == 4'(m), "R5", {f, irq_src_o}, {1'b1, 4'(m)});
      @(negedge clk);
      chk(irq_o == 0, "R9 pulse", irq_o, 0);
    end

    // R6 R8 R9: sweep thresholds and pre-event tick counts
    foreach (codes[c]) begin
      int t;
      t = int'(codes[c]);
      wr(32'(t) << 16);
      sync();
      for (int j = 0; j <= t + 2; j++) begin
        logic [N-1:0] m;
        int n, early;
        m = 4'((j % 15) + 1);
        early = 0;
        for (int k = 0; k < j; k++) begin tick(f); if (f) early++; end
        chk(early == 0, "R9 idle", early, 0);
        pulse(m, f);
        chk(f == 0, "R6 no immediate", f, 0);
        n = 0;
        for (int k = 0; k < 200 && !f; k++) begin tick(f); n++; end
        chk(j + n == ((j + 1 > t) ? j + 1 : t), "R6 R8 delay", j + n,
            (j + 1 > t) ? j + 1 : t);
        chk(irq_src_o == m, "R6 src", irq_src_o, m);
        @(negedge clk);
        chk(irq_o == 0, "R9 pulse", irq_o, 0);
      end
    end

    // R7 coalescing of several events within one interval
    begin
      int n;
      wr(32'h0010_0000);
      sync();
      pulse(4'b0001, f);
      repeat (3) tick(f);
      pulse(4'b0100, f);
      repeat (5) tick(f);
      pulse(4'b1000, f);
      n = 8;
      f = 0;
      for (int k = 0; k < 40 && !f; k++) begin tick(f); n++; end
      chk(n == 16, "R7 interval", n, 16);
      chk(irq_src_o == 4'b1101, "R7 OR", irq_src_o, 4'b1101);
      n = 0;
      for (int k = 0; k < 40; k++) begin tick(f); if (f) n++; end
      chk(n == 0, "R7 cleared", n, 0);
    end

    summary();
  end
endmodule